// File: doc/BRIEF.md
# Subsampled-Table Image Rectifier

This block warps a streaming 8-bit grayscale image into rectified form at one pixel per clock. The warp map is held only on a coarse grid, one entry every S pixels in each axis, so its storage shrinks by S squared. Each grid entry gives a signed horizontal and vertical displacement in fixed point. For every output coordinate the block blends the four surrounding grid entries into a source coordinate. It then blends the four source pixels nearest that coordinate into the output pixel. Only integer and fixed-point arithmetic is used.

Incoming pixels are written into a small circular line buffer. The buffer is split into four banks by the parity of the column and of the row, so the 2x2 neighbourhood of any source coordinate is read in a single cycle. The coarse table is split the same way for the same reason. The output stream carries the same framing as the input: a valid strobe, a start-of-frame marker and an end-of-line marker. It starts once enough input lines are held to cover the largest vertical displacement, set by the parameter LAG. The block cannot be stalled. The next frame's start must not arrive before the previous frame has fully left the block. The table is loaded through its own write port while no frame is in flight.

Top module: `stream_rectifier`

## Requirements
- R1: After reset, out_valid, out_sof and out_eol stay low until a frame has been received far enough to start output.
- R2: With every table entry zero, each output pixel equals the input pixel at the same coordinate.
- R3: With a uniform whole-pixel displacement (dx, dy), output (x, y) equals input (x+dx, y+dy).
- R4: The source coordinate has FB fractional bits, with F = 2^FB and fractions ax, ay. The output pixel is (sum of the four taps, each weighted (F-ax)(F-ay), ax(F-ay), (F-ax)ay or ax*ay, plus 2^(2FB-1)) shifted right by 2FB. The right-hand tap column and the lower tap row are clamped to the last image column and row.
- R5: The displacement at output (x, y) blends the entries at grid (gx, gy), (gx+1, gy), (gx, gy+1) and (gx+1, gy+1), where gx = x/S and fx = x mod S (likewise in y). The weights are (S-fx)(S-fy), fx(S-fy), (S-fx)fy and fx*fy. The sum is shifted right arithmetically by 2*log2(S), and a neighbour past the last grid column or row repeats the last one.
- R6: A table write with grid indices (gx, gy) and signed DW-bit values dx, dy holding FB fractional bits fixes the displacement at output pixel (gx*S, gy*S) to exactly (dx, dy).
- R7: The output pixel is 0 when the integer part of the source column lies outside 0..W-1. The same holds when the integer part of the source row lies outside 0..H-1 or outside oy-LAG..oy+LAG.
- R8: Each frame yields exactly W*H output pixels in raster order. out_sof is set only on the first of them, and out_eol is set exactly on column W-1.
- R9: No output pixel of a frame appears before LAG+2 input lines of that frame have ended.
- R10: Once a row of output has begun, its W pixels leave on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_eol | input | 1 | Input pixel is the last of its line |
| in_pix | input | 8 | Input pixel value |
| tbl_we | input | 1 | Write one coarse table entry |
| tbl_gx | input | clog2(W/S) | Grid column of the entry written |
| tbl_gy | input | clog2(H/S) | Grid row of the entry written |
| tbl_dx | input | DW | Signed horizontal displacement, FB fractional bits |
| tbl_dy | input | DW | Signed vertical displacement, FB fractional bits |
| out_valid | output | 1 | Output pixel present this cycle |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_eol | output | 1 | Output pixel is the last of its line |
| out_pix | output | 8 | Rectified pixel value |

## Verification
The bench builds the block with a 32x16 image, S = 4, FB = 4, DW = 8 and LAG = 1. This gives an 8x4 coarse grid and a six-line buffer. With these values a frame takes only a few hundred cycles. The right and bottom image edges, the clamped last grid column and row, and the vertical window limit are all reached by displacements of one or two pixels. A frame of constant 255 shows whether the rounded fractional blend can overflow.

// File: rtl/stream_rectifier.sv
module stream_rectifier #(
  parameter int W   = 640,
  parameter int H   = 480,
  parameter int S   = 16,
  parameter int FB  = 4,
  parameter int DW  = 8,
  parameter int LAG = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic                         in_sof,
  input  logic                         in_eol,
  input  logic [7:0]                   in_pix,
  input  logic                         tbl_we,
  input  logic [$clog2(W/S)-1:0]       tbl_gx,
  input  logic [$clog2(H/S)-1:0]       tbl_gy,
  input  logic signed [DW-1:0]         tbl_dx,
  input  logic signed [DW-1:0]         tbl_dy,
  output logic                         out_valid,
  output logic                         out_sof,
  output logic                         out_eol,
  output logic [7:0]                   out_pix
);

  localparam int SL    = $clog2(S);
  localparam int TW    = W / S;
  localparam int TH    = H / S;
  localparam int TWH   = (TW + 1) / 2;
  localparam int THH   = (TH + 1) / 2;
  localparam int GXW   = $clog2(TW);
  localparam int GYW   = $clog2(TH);
  localparam int XW    = $clog2(W);
  localparam int YW    = $clog2(H);
  localparam int TA    = $clog2(THH * TWH);
  localparam int LINES = 2 * LAG + 4;
  localparam int LH    = LINES / 2;
  localparam int WH    = W / 2;
  localparam int LA    = $clog2(LH * WH);
  localparam int F     = 1 << FB;

  // coarse table, four parity banks
  logic signed [DW-1:0] tdx [4][THH*TWH];
  logic signed [DW-1:0] tdy [4][THH*TWH];

  always_ff @(posedge clk)
    if (tbl_we) begin
      tdx[{tbl_gy[0], tbl_gx[0]}][TA'(int'(tbl_gy >> 1) * TWH + int'(tbl_gx >> 1))] <= tbl_dx;
      tdy[{tbl_gy[0], tbl_gx[0]}][TA'(int'(tbl_gy >> 1) * TWH + int'(tbl_gx >> 1))] <= tbl_dy;
    end

  // input side: line buffer writes and row bookkeeping
  logic [7:0]    lb [4][LH*WH];
  logic [XW-1:0] ix;
  logic [YW-1:0] iy;
  logic [YW:0]   rows_done;
  logic          frame_done;

  wire [XW-1:0] wx = in_sof ? '0 : ix;
  wire [YW-1:0] wy = in_sof ? '0 : iy;
  wire [LA-1:0] waddr = LA'((int'(wy) % LINES) / 2 * WH + int'(wx >> 1));

  always_ff @(posedge clk)
    if (in_valid) lb[{wy[0], wx[0]}][waddr] <= in_pix;

  always_ff @(posedge clk)
    if (rst) begin
      ix <= '0;
      iy <= '0;
      rows_done <= '0;
      frame_done <= 1'b0;
    end else if (in_valid) begin
      if (in_eol) begin
        ix <= '0;
        iy <= wy + 1'b1;
        rows_done <= {1'b0, wy} + 1'b1;
        frame_done <= (wy == YW'(H - 1));
      end else begin
        ix <= wx + 1'b1;
        iy <= wy;
        if (in_sof) begin
          rows_done <= '0;
          frame_done <= 1'b0;
        end
      end
    end

  // output coordinate sequencer
  logic          run;
  logic [XW-1:0] ox;
  logic [YW-1:0] oy;
  wire go = run && (frame_done || int'(rows_done) > int'(oy) + LAG + 1);

  always_ff @(posedge clk)
    if (rst) begin
      run <= 1'b0;
      ox <= '0;
      oy <= '0;
    end else if (in_valid && in_sof) begin
      run <= 1'b1;
      ox <= '0;
      oy <= '0;
    end else if (go) begin
      if (ox == XW'(W - 1)) begin
        ox <= '0;
        if (oy == YW'(H - 1)) run <= 1'b0;
        else oy <= oy + 1'b1;
      end else begin
        ox <= ox + 1'b1;
      end
    end

  // stage A: fetch four coarse entries
  wire [GXW-1:0] gx  = ox[XW-1:SL];
  wire [GYW-1:0] gy  = oy[YW-1:SL];
  wire [GXW-1:0] gx1 = (gx == GXW'(TW - 1)) ? gx : gx + 1'b1;
  wire [GYW-1:0] gy1 = (gy == GYW'(TH - 1)) ? gy : gy + 1'b1;

  logic [TA-1:0]        taddr [4];
  logic signed [DW-1:0] rdx [4], rdy [4];

  always_comb
    for (int b = 0; b < 4; b++) begin
      taddr[b] = TA'(int'(((gy[0] == 1'(b / 2)) ? gy : gy1) >> 1) * TWH
                   + int'(((gx[0] == 1'(b % 2)) ? gx : gx1) >> 1));
      rdx[b] = tdx[b][taddr[b]];
      rdy[b] = tdy[b][taddr[b]];
    end

  logic                 a_v, a_sof, a_eol;
  logic [XW-1:0]        a_ox;
  logic [YW-1:0]        a_oy;
  logic [SL-1:0]        a_fx, a_fy;
  logic signed [DW-1:0] a_dx [4], a_dy [4];

  always_ff @(posedge clk) begin
    a_v   <= rst ? 1'b0 : go;
    a_sof <= go && ox == '0 && oy == '0;
    a_eol <= go && ox == XW'(W - 1);
    a_ox  <= ox;
    a_oy  <= oy;
    a_fx  <= ox[SL-1:0];
    a_fy  <= oy[SL-1:0];
    a_dx[0] <= rdx[{gy[0], gx[0]}];   a_dy[0] <= rdy[{gy[0], gx[0]}];
    a_dx[1] <= rdx[{gy[0], gx1[0]}];  a_dy[1] <= rdy[{gy[0], gx1[0]}];
    a_dx[2] <= rdx[{gy1[0], gx[0]}];  a_dy[2] <= rdy[{gy1[0], gx[0]}];
    a_dx[3] <= rdx[{gy1[0], gx1[0]}]; a_dy[3] <= rdy[{gy1[0], gx1[0]}];
  end

  // stage B: source coordinate
  int ddx, ddy, sx, sy, x0, y0;
  logic inr;

  always_comb begin
    ddx = ((S - int'(a_fx)) * (S - int'(a_fy)) * int'(a_dx[0])
         + int'(a_fx) * (S - int'(a_fy)) * int'(a_dx[1])
         + (S - int'(a_fx)) * int'(a_fy) * int'(a_dx[2])
         + int'(a_fx) * int'(a_fy) * int'(a_dx[3])) >>> (2 * SL);
    ddy = ((S - int'(a_fx)) * (S - int'(a_fy)) * int'(a_dy[0])
         + int'(a_fx) * (S - int'(a_fy)) * int'(a_dy[1])
         + (S - int'(a_fx)) * int'(a_fy) * int'(a_dy[2])
         + int'(a_fx) * int'(a_fy) * int'(a_dy[3])) >>> (2 * SL);
    sx  = int'(a_ox) * F + ddx;
    sy  = int'(a_oy) * F + ddy;
    x0  = sx >>> FB;
    y0  = sy >>> FB;
    inr = x0 >= 0 && x0 <= W - 1 && y0 >= 0 && y0 <= H - 1
       && y0 >= int'(a_oy) - LAG && y0 <= int'(a_oy) + LAG;
  end

  logic          b_v, b_sof, b_eol, b_in;
  logic [XW-1:0] b_x0, b_x1;
  logic [YW-1:0] b_y0, b_y1;
  logic [FB-1:0] b_ax, b_ay;

  always_ff @(posedge clk) begin
    b_v   <= rst ? 1'b0 : a_v;
    b_sof <= a_sof;
    b_eol <= a_eol;
    b_in  <= inr;
    b_x0  <= XW'(x0);
    b_y0  <= YW'(y0);
    b_x1  <= XW'((x0 >= W - 1) ? x0 : x0 + 1);
    b_y1  <= YW'((y0 >= H - 1) ? y0 : y0 + 1);
    b_ax  <= sx[FB-1:0];
    b_ay  <= sy[FB-1:0];
  end

  // stage C: read the 2x2 source neighbourhood, one access per bank
  logic [LA-1:0] laddr [4];
  logic [7:0]    rpix [4];

  always_comb
    for (int b = 0; b < 4; b++) begin
      laddr[b] = LA'((int'((b_y0[0] == 1'(b / 2)) ? b_y0 : b_y1) % LINES) / 2 * WH
                   + int'(((b_x0[0] == 1'(b % 2)) ? b_x0 : b_x1) >> 1));
      rpix[b] = lb[b][laddr[b]];
    end

  logic          c_v, c_sof, c_eol, c_in;
  logic [7:0]    c_p [4];
  logic [FB-1:0] c_ax, c_ay;

  always_ff @(posedge clk) begin
    c_v    <= rst ? 1'b0 : b_v;
    c_sof  <= b_sof;
    c_eol  <= b_eol;
    c_in   <= b_in;
    c_ax   <= b_ax;
    c_ay   <= b_ay;
    c_p[0] <= rpix[{b_y0[0], b_x0[0]}];
    c_p[1] <= rpix[{b_y0[0], b_x1[0]}];
    c_p[2] <= rpix[{b_y1[0], b_x0[0]}];
    c_p[3] <= rpix[{b_y1[0], b_x1[0]}];
  end

  // stage D: pixel blend
  int blend;
  always_comb
    blend = ((F - int'(c_ax)) * (F - int'(c_ay)) * int'(c_p[0])
           + int'(c_ax) * (F - int'(c_ay)) * int'(c_p[1])
           + (F - int'(c_ax)) * int'(c_ay) * int'(c_p[2])
           + int'(c_ax) * int'(c_ay) * int'(c_p[3])
           + (1 << (2 * FB - 1))) >> (2 * FB);

  always_ff @(posedge clk) begin
    out_valid <= rst ? 1'b0 : c_v;
    out_sof   <= rst ? 1'b0 : c_v && c_sof;
    out_eol   <= rst ? 1'b0 : c_v && c_eol;
    out_pix   <= c_in ? blend[7:0] : 8'd0;
  end

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && !out_sof && !out_eol)
    else $error("output active straight after reset");

  // R8
  sof_opens_frame_chk: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid && !$past(out_valid))
    else $error("frame start not on a fresh output run");

  // R9
  lines_before_output_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sof |-> (int'(rows_done) >= LAG + 2 || frame_done))
    else $error("output began before enough lines were held");

  // R10
  row_unbroken_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_eol |=> out_valid)
    else $error("gap inside an output row");

endmodule

// File: tb/tb_stream_rectifier.sv
module tb_stream_rectifier;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32, H = 16, S = 4, FB = 4, DW = 8, LAG = 1;
  localparam int SL = 2, TW = W / S, TH = H / S, F = 1 << FB;
  localparam int GAP = 4;
  localparam int NSC = 7;
  // table mode (0 uniform, 1 gradient, 2 pseudo-random), dx, dy, image kind
  localparam int VEC [NSC][4] = '{
    '{0,   0,  0, 1},
    '{0,  32, 16, 0},
    '{0,   8, -4, 1},
    '{1,   0,  0, 0},
    '{0, -24, 32, 1},
    '{2,   0,  0, 1},
    '{0,   8, -4, 2}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_sof = 0, in_eol = 0;
  logic [7:0] in_pix = 0;
  logic tbl_we = 0;
  logic [$clog2(TW)-1:0] tbl_gx = 0;
  logic [$clog2(TH)-1:0] tbl_gy = 0;
  logic signed [DW-1:0] tbl_dx = 0, tbl_dy = 0;
  logic out_valid, out_sof, out_eol;
  logic [7:0] out_pix;

  stream_rectifier #(.W(W), .H(H), .S(S), .FB(FB), .DW(DW), .LAG(LAG)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_pix(in_pix), .tbl_we(tbl_we), .tbl_gx(tbl_gx), .tbl_gy(tbl_gy),
    .tbl_dx(tbl_dx), .tbl_dy(tbl_dy), .out_valid(out_valid), .out_sof(out_sof),
    .out_eol(out_eol), .out_pix(out_pix));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, failures = 0;
  int img [H][W];
  int tdxm [TH][TW], tdym [TH][TW];
  int got [W*H];
  int mon_cnt = 0, sof_err = 0, eol_err = 0, gap_err = 0, first_eols = 0, eols_sent = 0;
  bit prev_valid = 0;
  int seed = 7;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (out_valid) begin
      if (mon_cnt < W * H) got[mon_cnt] = int'(out_pix);
      if (out_sof != (mon_cnt == 0)) sof_err++;
      if (out_eol != (mon_cnt % W == W - 1)) eol_err++;
      if (mon_cnt % W != 0 && !prev_valid) gap_err++;
      if (mon_cnt == 0) first_eols = eols_sent;
      mon_cnt++;
    end
    prev_valid = out_valid;
  end

  function automatic int exp_pix(int ox, int oy);
    int gx = ox / S, gy = oy / S, fx = ox % S, fy = oy % S;
    int gx1 = (gx == TW - 1) ? gx : gx + 1;
    int gy1 = (gy == TH - 1) ? gy : gy + 1;
    int dx = ((S-fx)*(S-fy)*tdxm[gy][gx] + fx*(S-fy)*tdxm[gy][gx1]
            + (S-fx)*fy*tdxm[gy1][gx] + fx*fy*tdxm[gy1][gx1]) >>> (2*SL);
    int dy = ((S-fx)*(S-fy)*tdym[gy][gx] + fx*(S-fy)*tdym[gy][gx1]
            + (S-fx)*fy*tdym[gy1][gx] + fx*fy*tdym[gy1][gx1]) >>> (2*SL);
    int sx = ox * F + dx, sy = oy * F + dy;
    int x0 = sx >>> FB, y0 = sy >>> FB;
    int ax = sx - x0 * F, ay = sy - y0 * F;
    int x1, y1;
    if (x0 < 0 || x0 > W-1 || y0 < 0 || y0 > H-1 || y0 < oy - LAG || y0 > oy + LAG)
      return 0;
    x1 = (x0 == W-1) ? x0 : x0 + 1;
    y1 = (y0 == H-1) ? y0 : y0 + 1;
    return ((F-ax)*(F-ay)*img[y0][x0] + ax*(F-ay)*img[y0][x1]
          + (F-ax)*ay*img[y1][x0] + ax*ay*img[y1][x1] + F*F/2) >>> (2*FB);
  endfunction

  function automatic int rnd(int span);
    seed = seed * 1103515245 + 12345;
    return ((seed >> 16) & 32'hFFFF) % (2 * span + 1) - span;
  endfunction

  function automatic string tag(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2, 6: return "R4";
      4: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic build(int s);
    for (int gy = 0; gy < TH; gy++)
      for (int gx = 0; gx < TW; gx++) begin
        case (VEC[s][0])
          0: begin tdxm[gy][gx] = VEC[s][1]; tdym[gy][gx] = VEC[s][2]; end
          1: begin tdxm[gy][gx] = (gx - 4) * 3; tdym[gy][gx] = (gy - 2) * 5; end
          default: begin tdxm[gy][gx] = rnd(40); tdym[gy][gx] = rnd(14); end
        endcase
      end
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        case (VEC[s][3])
          0: img[y][x] = (x * 7 + y * 13) & 255;
          1: img[y][x] = ((x * 37) ^ (y * 91) ^ (x * y)) & 255;
          default: img[y][x] = 255;
        endcase
  endtask

  task automatic load_table();
    for (int gy = 0; gy < TH; gy++)
      for (int gx = 0; gx < TW; gx++) begin
        @(negedge clk);
        tbl_we = 1; tbl_gx = 3'(gx); tbl_gy = 2'(gy);
        tbl_dx = 8'(tdxm[gy][gx]); tbl_dy = 8'(tdym[gy][gx]);
      end
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic send_frame();
    eols_sent = 0;
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        @(negedge clk);
        in_valid = 1; in_sof = (x == 0 && y == 0); in_eol = (x == W - 1);
        in_pix = 8'(img[y][x]);
        if (x == W - 1) eols_sent++;
      end
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eol = 0;
      repeat (GAP - 1) @(negedge clk);
    end
  endtask

  task automatic run_scenario(int s);
    int mism = 0, fa = 0, fe = 0, gm = 0;
    build(s);
    load_table();
    mon_cnt = 0; sof_err = 0; eol_err = 0; gap_err = 0;
    send_frame();
    for (int i = 0; i < 4000 && mon_cnt < W * H; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        if (got[y * W + x] != exp_pix(x, y)) begin
          if (mism == 0) begin fa = got[y * W + x]; fe = exp_pix(x, y); end
          mism++;
          if (x % S == 0 && y % S == 0) gm++;
        end
    check(mism == 0, tag(s), $sformatf("scenario %0d first pixel mismatch of %0d", s, mism), fa, fe);
    check(mon_cnt == W * H && sof_err == 0 && eol_err == 0, "R8",
          $sformatf("scenario %0d pixel count, sof_err=%0d eol_err=%0d", s, sof_err, eol_err),
          mon_cnt, W * H);
    check(first_eols >= LAG + 2, "R9", $sformatf("scenario %0d lines ended before first output", s),
          first_eols, LAG + 2);
    check(gap_err == 0, "R10", $sformatf("scenario %0d gaps inside rows", s), gap_err, 0);
    if (s == 3)
      check(gm == 0, "R6", "grid-point pixels mismatching", gm, 0);
    if (s == 1)
      check(got[W - 1] == 0 && got[(H - 1) * W] == 0, "R7",
            "right/bottom pixels beyond the image", got[W - 1] + got[(H - 1) * W], 0);
  endtask

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst = 0;
    bad = 0;
    repeat (6) begin @(negedge clk); if (out_valid || out_sof || out_eol) bad++; end
    check(bad == 0, "R1", "outputs active after reset", bad, 0);
    for (int s = 0; s < NSC; s++) begin
      if (s == NSC - 1) begin
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        bad = 0;
        repeat (6) begin @(negedge clk); if (out_valid || out_sof || out_eol) bad++; end
        check(bad == 0, "R1", "outputs active after second reset", bad, 0);
      end
      run_scenario(s);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule